// File: doc/BRIEF.md
# Load Store-Alias Predictor

This block tells an out-of-order core whether a load that is about to issue is likely to collide with an older store that is still in flight. When the answer is "conflict", the core holds the load until the older stores have resolved. When the answer is "no conflict", the core lets the load run ahead speculatively. The prediction comes from a direct-mapped table indexed by bits of the load's program counter. Each table slot holds a valid flag and a small signed confidence counter.

The core reports back how each load ended. A load that a store alias killed pushes its slot's counter up by two steps. A load that had been killed earlier and now completes cleanly pulls the counter down by one step. This asymmetric training makes the predictor cautious after a kill and slow to forgive.

A free-running 16-bit LFSR, which advances once per training report, clears one slot at pseudo-random moments. This stops any slot from settling into a permanent stall when the aliasing that trained it has gone away.

Top module: `ld_alias_pred`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, every slot is invalid and `pred_valid` and `pred_conflict` are 0. The LFSR state is reset to 16'hACE1.
- R2: A lookup presented with `lkp_valid` high produces `pred_valid` = 1 on the next cycle. In that same cycle `pred_conflict` is 1 exactly when the slot is valid and its counter is at least 0. In any cycle without such a lookup, both outputs are 0.
- R3: The slot is selected by PC bits [9:2], so there are 256 slots. PCs that differ only in bits [1:0] or above bit 9 share a slot.
- R4: A report with `trn_killed` = 1 on a valid slot adds 2 to its counter, saturating at +7. The counter is 4-bit signed, with range -8 to +7.
- R5: A report with `trn_killed` = 1 on an invalid slot allocates that slot. The counter starts at the minimum, -8, the saturating +2 is then applied so the slot holds -6, and the slot becomes valid.
- R6: A report with `trn_killed` = 0 and `trn_prev_killed` = 1 on a valid slot subtracts 1, saturating at -8. On an invalid slot the same report leaves the slot invalid.
- R7: A report with `trn_killed` = 0 and `trn_prev_killed` = 0 leaves the slot unchanged.
- R8: Every report advances the LFSR. The next state is {s[14:0], s[15]^s[13]^s[12]^s[10]}. If s[7:0] == 0 at the moment of the report, the slot indexed by s[15:8] becomes invalid. This clear wins over a training write to the same slot in the same cycle.
- R9: When a lookup and a report address the same slot in the same cycle, the prediction uses the slot's contents from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lkp_valid | input | 1 | A load asks for a prediction this cycle |
| lkp_pc | input | 32 | PC of the load being looked up |
| trn_valid | input | 1 | A load outcome is reported this cycle |
| trn_pc | input | 32 | PC of the reported load |
| trn_killed | input | 1 | The reported load was killed by a store alias |
| trn_prev_killed | input | 1 | The reported load had been killed on an earlier attempt |
| pred_valid | output | 1 | A prediction is presented (one cycle after the lookup) |
| pred_conflict | output | 1 | Predict an alias; hold the load |

## Verification
Both prediction outputs are registered, so each result is due exactly one clock after the cycle in which its lookup was driven. A training report changes the table on the edge that samples it, so it first affects a lookup driven in the following cycle. The bench drives inputs on the falling edge and advances a behavioural table model on the rising edge. The model records the outcome the design owes for that edge, and the bench compares it with the outputs on the next falling edge, before new inputs are driven. Directed phases cover saturation at both ends, allocation, slot aliasing and same-slot collisions. Long random phases with a narrow PC pool make the pseudo-random clears land on trained slots.

// File: rtl/ld_alias_pkg.sv
package ld_alias_pkg;
  typedef enum logic [1:0] {
    UPD_NONE  = 2'd0,
    UPD_KILL  = 2'd1,
    UPD_CLEAN = 2'd2
  } upd_kind_e;
endpackage

// File: rtl/ld_alias_lfsr.sv
module ld_alias_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] state
);
  logic [W-1:0] st_q;
  logic         fb;

  assign fb    = ^(st_q & TAPS);
  assign state = st_q;

  always_ff @(posedge clk) begin
    if (rst)      st_q <= SEED;
    else if (adv) st_q <= {st_q[W-2:0], fb};
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
    st_q != '0);                                       // R8
  AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(st_q));                           // R8
endmodule

// File: rtl/ld_alias_ctr_upd.sv
module ld_alias_ctr_upd
  import ld_alias_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int KILL_STEP  = 2,
  parameter int CLEAN_STEP = 1
) (
  input  upd_kind_e               kind,
  input  logic                    old_vld,
  input  logic signed [CNT_W-1:0] old_cnt,
  output logic                    we,
  output logic signed [CNT_W-1:0] new_cnt
);
  localparam int CMAX = (2 ** (CNT_W - 1)) - 1;
  localparam int CMIN = -(2 ** (CNT_W - 1));

  int base;
  int sum;

  always_comb begin
    we      = 1'b0;
    base    = int'(old_cnt);
    sum     = base;
    case (kind)
      UPD_KILL: begin
        we   = 1'b1;
        base = old_vld ? int'(old_cnt) : CMIN;
        sum  = base + KILL_STEP;
      end
      UPD_CLEAN: begin
        we   = old_vld;
        sum  = base - CLEAN_STEP;
      end
      default: begin
        we   = 1'b0;
      end
    endcase
    if (sum > CMAX) sum = CMAX;
    if (sum < CMIN) sum = CMIN;
    new_cnt = CNT_W'(sum);
  end
endmodule

// File: rtl/ld_alias_table.sv
module ld_alias_table #(
  parameter int IDX_W = 8,
  parameter int CNT_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [IDX_W-1:0]        lk_idx,
  output logic                    lk_vld,
  output logic signed [CNT_W-1:0] lk_cnt,
  input  logic [IDX_W-1:0]        tr_idx,
  output logic                    tr_vld,
  output logic signed [CNT_W-1:0] tr_cnt,
  input  logic                    wr_en,
  input  logic signed [CNT_W-1:0] wr_cnt,
  input  logic                    clr_en,
  input  logic [IDX_W-1:0]        clr_idx
);
  localparam int DEPTH = 2 ** IDX_W;

  logic [DEPTH-1:0]        vld_q;
  logic signed [CNT_W-1:0] cnt_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      if (wr_en)  vld_q[tr_idx]  <= 1'b1;
      if (clr_en) vld_q[clr_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) cnt_mem[tr_idx] <= wr_cnt;
  end

  assign lk_vld = vld_q[lk_idx];
  assign lk_cnt = cnt_mem[lk_idx];
  assign tr_vld = vld_q[tr_idx];
  assign tr_cnt = cnt_mem[tr_idx];

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> !vld_q[$past(clr_idx)]);                // R8
  AST_WR_ALLOCS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !(clr_en && clr_idx == tr_idx)) |=> vld_q[$past(tr_idx)]);  // R5
endmodule

// File: rtl/ld_alias_pred.sv
module ld_alias_pred
  import ld_alias_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int IDX_W      = 8,
  parameter int IDX_LSB    = 2,
  parameter int CNT_W      = 4,
  parameter int LFSR_W     = 16,
  parameter int ZERO_BITS  = 8,
  parameter int KILL_STEP  = 2,
  parameter int CLEAN_STEP = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lkp_valid,
  input  logic [PC_W-1:0] lkp_pc,
  input  logic            trn_valid,
  input  logic [PC_W-1:0] trn_pc,
  input  logic            trn_killed,
  input  logic            trn_prev_killed,
  output logic            pred_valid,
  output logic            pred_conflict
);
  localparam int IDX_HI = IDX_LSB + IDX_W - 1;

  logic [IDX_W-1:0]        lk_idx, tr_idx, clr_idx;
  logic                    lk_vld, tr_vld, wr_en, upd_we, clr_en;
  logic signed [CNT_W-1:0] lk_cnt, tr_cnt, wr_cnt;
  logic [LFSR_W-1:0]       rnd;
  upd_kind_e               kind;
  logic                    pv_q, pc_q;

  assign lk_idx = lkp_pc[IDX_HI:IDX_LSB];
  assign tr_idx = trn_pc[IDX_HI:IDX_LSB];

  always_comb begin
    if (!trn_valid)           kind = UPD_NONE;
    else if (trn_killed)      kind = UPD_KILL;
    else if (trn_prev_killed) kind = UPD_CLEAN;
    else                      kind = UPD_NONE;
  end

  ld_alias_lfsr #(.W(LFSR_W)) u_lfsr (
    .clk   (clk),
    .rst   (rst),
    .adv   (trn_valid),
    .state (rnd)
  );

  assign clr_en  = trn_valid && (rnd[ZERO_BITS-1:0] == '0);
  assign clr_idx = rnd[LFSR_W-1 -: IDX_W];

  ld_alias_ctr_upd #(
    .CNT_W(CNT_W), .KILL_STEP(KILL_STEP), .CLEAN_STEP(CLEAN_STEP)
  ) u_upd (
    .kind    (kind),
    .old_vld (tr_vld),
    .old_cnt (tr_cnt),
    .we      (upd_we),
    .new_cnt (wr_cnt)
  );

  assign wr_en = upd_we;

  ld_alias_table #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_tbl (
    .clk     (clk),
    .rst     (rst),
    .lk_idx  (lk_idx),
    .lk_vld  (lk_vld),
    .lk_cnt  (lk_cnt),
    .tr_idx  (tr_idx),
    .tr_vld  (tr_vld),
    .tr_cnt  (tr_cnt),
    .wr_en   (wr_en),
    .wr_cnt  (wr_cnt),
    .clr_en  (clr_en),
    .clr_idx (clr_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pv_q <= 1'b0;
      pc_q <= 1'b0;
    end else begin
      pv_q <= lkp_valid;
      pc_q <= lkp_valid && lk_vld && !lk_cnt[CNT_W-1];
    end
  end

  assign pred_valid    = pv_q;
  assign pred_conflict = pc_q;

  AST_CONF_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    pred_conflict |-> pred_valid);                     // R2
  AST_PRED_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    lkp_valid |=> pred_valid);                         // R2
  AST_PRED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !lkp_valid |=> !pred_valid);                       // R2
endmodule

// File: tb/ld_alias_pred_tb.sv
module ld_alias_pred_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lkp_valid = 1'b0;
  logic [31:0] lkp_pc = '0;
  logic        trn_valid = 1'b0;
  logic [31:0] trn_pc = '0;
  logic        trn_killed = 1'b0;
  logic        trn_prev_killed = 1'b0;
  logic        pred_valid, pred_conflict;

  ld_alias_pred u_dut (
    .clk(clk), .rst(rst),
    .lkp_valid(lkp_valid), .lkp_pc(lkp_pc),
    .trn_valid(trn_valid), .trn_pc(trn_pc),
    .trn_killed(trn_killed), .trn_prev_killed(trn_prev_killed),
    .pred_valid(pred_valid), .pred_conflict(pred_conflict)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  bit    m_vld [256];
  int    m_cnt [256];
  int    m_lfsr;
  bit    exp_pv, exp_pc;
  int    n_vec = 0, n_bad = 0, cycles = 0;
  string tag = "R1";

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      foreach (m_vld[i]) m_vld[i] = 0;
      m_lfsr = 16'hACE1;
      exp_pv = 0;
      exp_pc = 0;
    end else begin
      int li, ti, ci, fb;
      li = int'(lkp_pc[9:2]);
      ti = int'(trn_pc[9:2]);
      exp_pv = lkp_valid;
      exp_pc = lkp_valid && m_vld[li] && (m_cnt[li] >= 0);
      if (trn_valid) begin
        if (trn_killed) begin
          if (!m_vld[ti]) m_cnt[ti] = -8;
          m_cnt[ti] = (m_cnt[ti] + 2 > 7) ? 7 : m_cnt[ti] + 2;
          m_vld[ti] = 1;
        end else if (trn_prev_killed && m_vld[ti]) begin
          m_cnt[ti] = (m_cnt[ti] - 1 < -8) ? -8 : m_cnt[ti] - 1;
        end
        if ((m_lfsr & 255) == 0) begin
          ci = (m_lfsr >> 8) & 255;
          m_vld[ci] = 0;
        end
        fb = ((m_lfsr >> 15) ^ (m_lfsr >> 13) ^ (m_lfsr >> 12) ^ (m_lfsr >> 10)) & 1;
        m_lfsr = ((m_lfsr << 1) & 16'hFFFF) | fb;
      end
    end
  end

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  task automatic compare();
    n_vec++;
    if (pred_valid !== exp_pv || pred_conflict !== exp_pc) begin
      n_bad++;
      $display("FAIL %s: valid/conflict got %0b/%0b expected %0b/%0b at cycle %0d",
               tag, pred_valid, pred_conflict, exp_pv, exp_pc, cycles);
    end
  endtask

  task automatic step(input bit lv, input logic [31:0] lpc, input bit tv,
                      input logic [31:0] tpc, input bit k, input bit pk);
    @(negedge clk);
    compare();
    if (cycles > WATCHDOG) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
    lkp_valid = lv; lkp_pc = lpc;
    trn_valid = tv; trn_pc = tpc; trn_killed = k; trn_prev_killed = pk;
  endtask

  task automatic idle();
    step(0, '0, 0, '0, 0, 0);
  endtask

  task automatic look(input logic [31:0] pc);
    step(1, pc, 0, '0, 0, 0);
    idle();
  endtask

  initial begin
    // R1: reset state
    tag = "R1";
    repeat (4) step(1, 32'h40, 0, '0, 0, 0);
    rst = 1'b0;
    look(32'h40);
    idle();

    // R5: kill on invalid slot allocates at -6 (no conflict yet)
    tag = "R5";
    step(0, '0, 1, 32'h100, 1, 0);
    look(32'h100);
    // R4: further kills +2: -4, -2, 0 -> conflict
    tag = "R4";
    for (int i = 0; i < 3; i++) begin
      step(0, '0, 1, 32'h100, 1, 0);
      look(32'h100);
    end
    for (int i = 0; i < 6; i++) step(0, '0, 1, 32'h100, 1, 0); // saturate at +7
    look(32'h100);
    // R3: aliases on bits [1:0] and above bit 9 share the slot
    tag = "R3";
    look(32'h103);
    look(32'hFFFF_FD00);
    look(32'h104);
    // R7: clean report without prior kill changes nothing
    tag = "R7";
    for (int i = 0; i < 10; i++) step(0, '0, 1, 32'h100, 0, 0);
    look(32'h100);
    // R6: clean reports after kill step down from +7, saturating at -8
    tag = "R6";
    for (int i = 0; i < 20; i++) begin
      step(0, '0, 1, 32'h100, 0, 1);
      look(32'h100);
    end
    step(0, '0, 1, 32'h200, 0, 1);   // invalid slot stays invalid
    look(32'h200);
    // R9: same-slot lookup and kill in one cycle sees the old value
    tag = "R9";
    step(0, '0, 1, 32'h100, 1, 0);
    step(0, '0, 1, 32'h100, 1, 0);
    step(0, '0, 1, 32'h100, 1, 0);
    step(0, '0, 1, 32'h100, 1, 0);   // now at 0
    step(1, 32'h100, 1, 32'h100, 0, 1); // old 0 -> conflict, becomes -1
    look(32'h100);
    // R2: back-to-back lookups across slots
    tag = "R2";
    for (int i = 0; i < 40; i++) step(1, 32'(i * 4), 0, '0, 0, 0);
    idle();

    // R8: random traffic on a narrow pool so pseudo-random clears hit live slots
    tag = "R8";
    for (int i = 0; i < 40000; i++) begin
      logic [31:0] a, b;
      a = {$urandom} & 32'h0000_F03F;
      b = {$urandom} & 32'h0000_F03F;
      step($urandom_range(0, 1), a, $urandom_range(0, 3) != 0, b,
           $urandom_range(0, 2) == 0, $urandom_range(0, 1));
    end
    // R8 wide index range
    for (int i = 0; i < 20000; i++) begin
      step(1, {$urandom}, 1, {$urandom}, $urandom_range(0, 1), $urandom_range(0, 1));
    end
    idle();
    idle();
    finish_run();
  end
endmodule